// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block is a non-blocking time-slot switch for 384 channels of 64 kb/s traffic: 256 bus-side channels and 128 local channels. A free-running channel counter, realigned by a frame pulse, walks the channel slots. In every slot the byte presented on the parallel input port is stored in that channel's own location of a byte-wide data memory. In the same slot, the output port produces the byte chosen by that channel's 12-bit connection word. That byte is either a stored sample picked by a 9-bit source address (switched connection) or a constant held in the word (message). Any number of outputs may name the same source, which gives broadcast.

The connection word also carries an output-enable flag and, for bus-side channels, a direction flag. The direction flag marks which member of a paired input/output channel acts as the input. A small register-style processor port, with an 8-bit data path and a 2-bit register address, reads and writes both memories. A connection word is written in two steps: the low byte is held in a staging register, and the full word is committed only when the upper nibble is written.

Top module: `tsi_switch_core`

## Requirements
- R1: `slot` is 0 in the cycle after reset or after a cycle with `frame_start` high. Otherwise it advances by one each cycle and wraps from 383 to 0.
- R2: In every cycle the byte on `in_byte` is stored at data-memory location `slot`. The processor can read that location back.
- R3: Connection word layout: bits [8:0] are the source address, bit 9 is output enable, bit 10 selects message mode, and bit 11 is direction. With bit 9 = 1 and bit 10 = 0, `out_byte` is the data-memory byte at the source address as stored before this cycle's write. A channel that selects its own slot therefore sees its previous frame's byte.
- R4: With bits 9 and 10 both set, `out_byte` equals word bits [7:0], and bit 8 has no effect.
- R5: With bit 9 clear, `out_drive` is 0 and `out_byte` is 0xFF. After reset every connection word is 0 and every data byte is 0xFF.
- R6: `out_dir` equals word bit 11 for slots 0..255 and is 0 for local slots 256..383.
- R7: Writing register 0 with the connection memory targeted only stages the byte, and the stored word is unchanged. Writing register 1 commits {wdata[3:0], staged byte} to the indexed word.
- R8: Writing register 0 with the data memory targeted stores the byte at the index. The next sample for that channel overwrites it, and the sample wins when both land in the same cycle.
- R9: Register map: 0 = low data, 1 = high data, 2 = index bits [7:0], 3 = index bit 8 in bit 0 and target in bit 7 (1 = connection memory, 0 = data memory). Register 0 reads the targeted byte, or the low 8 bits of the connection word. Register 1 reads {4'b0, word[11:8]} for the connection target and 0 for the data target. Registers 2 and 3 read back the index and target, with unused bits 0. Registers 0 and 1 read 0 when the index is 384 or above.
- R10: A switched connection whose source address is 384 or above outputs 0xFF with `out_drive` still 1.
- R11: Several outputs that select the same source all output that source's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Realigns the channel counter to slot 0 in the next cycle |
| in_byte | input | 8 | Input sample for the current slot |
| slot | output | 9 | Current channel slot |
| out_byte | output | 8 | Output byte for the current slot |
| out_drive | output | 1 | Output enable for the current slot |
| out_dir | output | 1 | Direction flag for the current slot |
| cpu_sel | input | 1 | Processor access strobe |
| cpu_wr | input | 1 | Write when high, read otherwise |
| cpu_addr | input | 2 | Processor register address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data for `cpu_addr` |

## Verification
The bench builds the block with its default sizes of 256 bus-side and 128 local channels. At these sizes the full 384-slot wrap, the boundary between bus and local slots at 256 and out-of-range source addresses above 383 are all reachable within a few frames. A behavioural model tracks both memories, the staging register and the index. Every cycle it compares the slot, the output byte, the drive and direction flags and the processor read data. This covers loopback, broadcast, message mode and staged commits as they occur.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int SRC_W  = 9;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef struct packed {
        logic              dir;
        logic              msg;
        logic              oe;
        logic [SRC_W-1:0]  src;
    } conn_t;

    typedef enum logic [1:0] {
        REG_DLO = 2'd0,
        REG_DHI = 2'd1,
        REG_ILO = 2'd2,
        REG_IHI = 2'd3
    } reg_t;

    function automatic logic in_range(logic [SRC_W-1:0] a, int n);
        return int'(a) < n;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(conn_t w, logic [BYTE_W-1:0] stored);
        if (!w.oe)       return IDLE_BYTE;
        else if (w.msg)  return w.src[BYTE_W-1:0];
        else             return stored;
    endfunction
endpackage

// File: rtl/tsi_slot_counter.sv
module tsi_slot_counter
    import tsi_pkg::*;
#(
    parameter int NCH = 384
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    output logic [SRC_W-1:0] slot
);
    localparam logic [SRC_W-1:0] LAST = SRC_W'(NCH - 1);

    always_ff @(posedge clk) begin
        if (rst || frame_start) slot <= '0;
        else if (slot == LAST)  slot <= '0;
        else                    slot <= slot + 1'b1;
    end

    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && slot == LAST) |=> slot == '0);
    p_realign_r1: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> slot == '0);
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int NCH = 384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  s_addr,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              c_we,
    input  logic [SRC_W-1:0]  c_addr,
    input  logic [BYTE_W-1:0] c_data,
    input  logic [SRC_W-1:0]  r_addr,
    output logic [BYTE_W-1:0] r_data,
    input  logic [SRC_W-1:0]  p_addr,
    output logic [BYTE_W-1:0] p_data
);
    logic [BYTE_W-1:0] mem [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) mem[i] <= IDLE_BYTE;
        end else begin
            if (c_we && in_range(c_addr, NCH)) mem[c_addr] <= c_data;
            if (in_range(s_addr, NCH))         mem[s_addr] <= s_data;
        end
    end

    assign r_data = in_range(r_addr, NCH) ? mem[r_addr] : IDLE_BYTE;
    assign p_data = in_range(p_addr, NCH) ? mem[p_addr] : IDLE_BYTE;

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        in_range(s_addr, NCH) |=> mem[$past(s_addr)] == $past(s_data));
    p_cpu_store_r8: assert property (@(posedge clk) disable iff (rst)
        (c_we && in_range(c_addr, NCH) && c_addr != s_addr)
        |=> mem[$past(c_addr)] == $past(c_data));
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int NCH = 384
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SRC_W-1:0] waddr,
    input  conn_t            wdata,
    input  logic [SRC_W-1:0] r_addr,
    output conn_t            r_word,
    input  logic [SRC_W-1:0] p_addr,
    output conn_t            p_word
);
    conn_t mem [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) mem[i] <= '0;
        end else if (we && in_range(waddr, NCH)) begin
            mem[waddr] <= wdata;
        end
    end

    assign r_word = in_range(r_addr, NCH) ? mem[r_addr] : '0;
    assign p_word = in_range(p_addr, NCH) ? mem[p_addr] : '0;

    p_commit_r7: assert property (@(posedge clk) disable iff (rst)
        (we && in_range(waddr, NCH)) |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port
    import tsi_pkg::*;
#(
    parameter int NCH = 384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [SRC_W-1:0]  idx,
    output logic              dm_we,
    output logic [BYTE_W-1:0] dm_wdata,
    output logic              cm_we,
    output conn_t             cm_wdata,
    input  logic [BYTE_W-1:0] dm_rdata,
    input  conn_t             cm_rdata
);
    logic              tgt_conn;
    logic [BYTE_W-1:0] stage;
    logic              wr_go;
    reg_t              ra;
    logic              idx_ok;

    assign ra     = reg_t'(addr);
    assign wr_go  = sel && wr;
    assign idx_ok = in_range(idx, NCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            tgt_conn <= 1'b0;
            stage    <= '0;
        end else if (wr_go) begin
            case (ra)
                REG_DLO: if (tgt_conn) stage <= wdata;
                REG_ILO: idx[7:0] <= wdata;
                REG_IHI: begin
                    idx[8]   <= wdata[0];
                    tgt_conn <= wdata[7];
                end
                default: ;
            endcase
        end
    end

    assign dm_we    = wr_go && ra == REG_DLO && !tgt_conn;
    assign dm_wdata = wdata;
    assign cm_we    = wr_go && ra == REG_DHI && tgt_conn;
    assign cm_wdata = conn_t'({wdata[3:0], stage});

    always_comb begin
        rdata = '0;
        case (ra)
            REG_DLO: if (idx_ok) rdata = tgt_conn ? cm_rdata.src[7:0] : dm_rdata;
            REG_DHI: if (idx_ok && tgt_conn) rdata = {4'b0, cm_rdata.dir, cm_rdata.msg,
                                                      cm_rdata.oe, cm_rdata.src[8]};
            REG_ILO: rdata = idx[7:0];
            REG_IHI: rdata = {tgt_conn, 6'b0, idx[8]};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
    import tsi_pkg::*;
#(
    parameter int N_BUS = 256,
    parameter int N_LOC = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start,
    input  logic [7:0]  in_byte,
    output logic [8:0]  slot,
    output logic [7:0]  out_byte,
    output logic        out_drive,
    output logic        out_dir,
    input  logic        cpu_sel,
    input  logic        cpu_wr,
    input  logic [1:0]  cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata
);
    localparam int NCH = N_BUS + N_LOC;

    logic [SRC_W-1:0]  idx;
    logic              dm_we, cm_we;
    logic [BYTE_W-1:0] dm_wdata, dm_sel_byte, dm_cpu_byte;
    conn_t             cm_wdata, cur_word, cpu_word;

    tsi_slot_counter #(.NCH(NCH)) u_cnt (
        .clk(clk), .rst(rst), .frame_start(frame_start), .slot(slot)
    );

    tsi_conn_mem #(.NCH(NCH)) u_cmem (
        .clk(clk), .rst(rst), .we(cm_we), .waddr(idx), .wdata(cm_wdata),
        .r_addr(slot), .r_word(cur_word), .p_addr(idx), .p_word(cpu_word)
    );

    tsi_data_mem #(.NCH(NCH)) u_dmem (
        .clk(clk), .rst(rst), .s_addr(slot), .s_data(in_byte),
        .c_we(dm_we), .c_addr(idx), .c_data(dm_wdata),
        .r_addr(cur_word.src), .r_data(dm_sel_byte),
        .p_addr(idx), .p_data(dm_cpu_byte)
    );

    tsi_cpu_port #(.NCH(NCH)) u_cpu (
        .clk(clk), .rst(rst), .sel(cpu_sel), .wr(cpu_wr), .addr(cpu_addr),
        .wdata(cpu_wdata), .rdata(cpu_rdata), .idx(idx),
        .dm_we(dm_we), .dm_wdata(dm_wdata), .cm_we(cm_we), .cm_wdata(cm_wdata),
        .dm_rdata(dm_cpu_byte), .cm_rdata(cpu_word)
    );

    assign out_byte  = pick_byte(cur_word, dm_sel_byte);
    assign out_drive = cur_word.oe;
    assign out_dir   = (int'(slot) < N_BUS) ? cur_word.dir : 1'b0;

    p_undriven_ff_r5: assert property (@(posedge clk) disable iff (rst)
        !out_drive |-> out_byte == IDLE_BYTE);
    p_local_dir_r6: assert property (@(posedge clk) disable iff (rst)
        (int'(slot) >= N_BUS) |-> !out_dir);
    p_stage_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_sel && cpu_wr && cpu_addr == 2'd0 && !dm_we) |=> $stable(cpu_word));
    p_slot_range_r1: assert property (@(posedge clk) disable iff (rst)
        int'(slot) < NCH);
endmodule

// File: tb/tsi_switch_core_bench.sv
`timescale 1ns/1ps
module tsi_switch_core_bench;
    localparam int NCH = 384;
    localparam int NBUS = 256;

    logic       clk = 0, rst = 1, frame_start = 0;
    logic [7:0] in_byte = 0;
    logic [8:0] slot;
    logic [7:0] out_byte, cpu_rdata;
    logic       out_drive, out_dir;
    logic       cpu_sel = 0, cpu_wr = 0;
    logic [1:0] cpu_addr = 0;
    logic [7:0] cpu_wdata = 0;

    always #10 clk = ~clk;

    tsi_switch_core u_tsi_switch_core (
        .clk(clk), .rst(rst), .frame_start(frame_start), .in_byte(in_byte),
        .slot(slot), .out_byte(out_byte), .out_drive(out_drive), .out_dir(out_dir),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    // behavioural model
    int m_d[NCH];
    int m_c[NCH];
    int m_slot, m_idx, m_tgt, m_stage;
    int nchk = 0, nfail = 0, cyc = 0;
    bit started = 0, done = 0;
    string phase = "R5";

    always @(posedge clk) begin
        started = 1;
        cyc++;
        if (rst) begin
            foreach (m_d[i]) m_d[i] = 'hFF;
            foreach (m_c[i]) m_c[i] = 0;
            m_slot = 0; m_idx = 0; m_tgt = 0; m_stage = 0;
        end else begin
            if (cpu_sel && cpu_wr) begin
                case (cpu_addr)
                    2'd0: if (m_tgt != 0) m_stage = cpu_wdata;
                          else if (m_idx < NCH) m_d[m_idx] = cpu_wdata;
                    2'd1: if (m_tgt != 0 && m_idx < NCH) m_c[m_idx] = (cpu_wdata % 16) * 256 + m_stage;
                    2'd2: m_idx = (m_idx / 256) * 256 + cpu_wdata;
                    default: begin
                        m_idx = (m_idx % 256) + (cpu_wdata % 2) * 256;
                        m_tgt = cpu_wdata / 128;
                    end
                endcase
            end
            m_d[m_slot] = in_byte;
            m_slot = frame_start ? 0 : (m_slot == NCH - 1 ? 0 : m_slot + 1);
        end
    end

    function automatic int exp_out(int c);
        int src = c % 512;
        if (((c >> 9) & 1) == 0) return 'hFF;
        if (((c >> 10) & 1) == 1) return c % 256;
        return (src < NCH) ? m_d[src] : 'hFF;
    endfunction

    function automatic string out_tag(int c, int s);
        int src = c % 512;
        if (((c >> 9) & 1) == 0) return "R5";
        if (((c >> 10) & 1) == 1) return "R4";
        if (src >= NCH) return "R10";
        if (src == s) return "R3";
        if (src == 300) return "R11";
        return "R3";
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            0: return (m_idx >= NCH) ? 0 : (m_tgt != 0 ? m_c[m_idx] % 256 : m_d[m_idx]);
            1: return (m_idx < NCH && m_tgt != 0) ? m_c[m_idx] / 256 : 0;
            2: return m_idx % 256;
            default: return m_tgt * 128 + m_idx / 256;
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h (slot %0d)", tag, what, act, expv, m_slot);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            int c;
            c = m_c[m_slot];
            chk("R1", "slot", int'(slot), m_slot);
            chk(out_tag(c, m_slot), "out_byte", int'(out_byte), exp_out(c));
            chk(out_tag(c, m_slot), "out_drive", int'(out_drive), (c >> 9) & 1);
            chk("R6", "out_dir", int'(out_dir), (m_slot < NBUS) ? ((c >> 11) & 1) : 0);
            chk(phase, "cpu_rdata", int'(cpu_rdata), exp_rd(int'(cpu_addr)));
        end
    end

    // input sample pattern, changed away from the edge
    always @(posedge clk) begin
        #2 in_byte = 8'((cyc * 37 + 11) % 256);
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic cpu_write(int a, int v);
        @(posedge clk); #2;
        cpu_sel = 1; cpu_wr = 1; cpu_addr = 2'(a); cpu_wdata = 8'(v);
        @(posedge clk); #2;
        cpu_sel = 0; cpu_wr = 0;
    endtask

    task automatic look(int a, int n);
        @(posedge clk); #2;
        cpu_addr = 2'(a);
        step(n);
    endtask

    task automatic set_index(int i, int tgt);
        cpu_write(2, i % 256);
        cpu_write(3, tgt * 128 + i / 256);
    endtask

    task automatic set_conn(int ch, int word);
        set_index(ch, 1);
        cpu_write(0, word % 256);
        cpu_write(1, word / 256);
    endtask

    initial begin
        step(3);
        rst = 0;
        phase = "R5";
        look(0, 4);
        look(1, 2);
        phase = "R1";
        frame_start = 1; step(1); frame_start = 0;
        step(400);
        frame_start = 1; step(1); frame_start = 0;
        step(20);
        phase = "R9";
        set_index(10, 1); look(2, 2); look(3, 2);
        set_index(300, 0); look(3, 2); look(1, 2);
        set_index(450, 1); look(0, 2); look(1, 2);
        phase = "R2";
        set_index(7, 0); look(0, 400);
        // connections: oe=bit9, msg=bit10, dir=bit11
        phase = "R3";  set_conn(5,   'h200 + 5);
        phase = "R3";  set_conn(10,  'h200 + 300);
        phase = "R11"; set_conn(11,  'h200 + 300);
                       set_conn(200, 'h200 + 300);
        phase = "R4";  set_conn(20,  'h400 + 'h200 + 'h100 + 'h5A);
        phase = "R5";  set_conn(30,  'h400 + 'h77);
        phase = "R6";  set_conn(40,  'h800 + 'h200 + 1);
                       set_conn(300, 'h800 + 'h200 + 2);
        phase = "R10"; set_conn(50,  'h200 + 400);
        phase = "R3";  step(800);
        phase = "R7";
        set_index(60, 1);
        cpu_write(0, 'h33); look(0, 3); look(1, 3);
        cpu_write(1, 'h6);  look(0, 3); look(1, 3);
        step(400);
        phase = "R8";
        frame_start = 1; step(1); frame_start = 0;
        step(10);
        set_index(150, 0);
        cpu_write(0, 'hC3); look(0, 200);
        set_index(0, 0);
        cpu_write(0, 'h11); look(0, 400);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule